// File: doc/BRIEF.md
# Sideband Upstream Request Issuer

This block lets firmware compose one outbound sideband request at a time and send it through memory-mapped registers. Firmware first programs the request: destination, opcode, byte enables, a BAR selector, a function ID, the address and a data word. It then writes the command register with the launch bit set. The block takes a snapshot of the programmed fields and offers them on a valid/ready request port until the fabric accepts them.

There are two sequencers, one for posted requests and one for non-posted requests. The posted sequencer goes idle once the request is accepted. The non-posted sequencer stays busy until the matching completion returns. The block then captures the completion's data, SAI, status and header flag. Two sticky write-1-to-clear status bits report the outcome: one for "request sent" and one for "completion received". Each has its own interrupt gate.

Top module: `sb_req_issuer`

## Requirements
- R1: After reset every writable field reads 0, the busy bit reads 0 and `reqValid` is low. The SAI register reads the `SAI_RESET` parameter in bits [SAI_W-1:0], root space 0 in bits [19:16] and a 1 in bit 31.
- R2: A write to offset 0 with bit 0 set launches exactly one request, and `reqValid` is high from the next cycle. While `reqValid` is high and `reqReady` is low, `reqValid` and all request fields hold steady. `reqValid` drops after the cycle in which both are high.
- R3: Bit 0 of the command register (offset 0) always reads 0. Bits [3:1] read back the stored read, posted and sent-interrupt-enable bits.
- R4: A launch is dropped, with no request and no busy, when the opcode (ATTR bits [15:8], offset 2) is in the range 0x20 to 0x2F. Opcodes 0x1F and 0x30 launch normally.
- R5: A launch written while either sequencer is busy is dropped.
- R6: Command bit 2 selects posted (1) or non-posted (0), and command bit 1 selects read (1) or write (0). A posted request always goes out with `reqRead` low.
- R7: Status bit 0 (offset 1) is busy: the OR of the two sequencers. The non-posted sequencer stays busy from launch until its completion is captured.
- R8: Status bit 1 is set when a request is accepted and is cleared by writing 1 to it. `sentIrq` equals that bit ANDed with command bit 3, and the enable does not change the status.
- R9: `reqMisc` is {ADDRHI bit 31, ATTR bits [22:20]}; ATTR bit 23 is not sent. When ADDRHI bit 31 is 0, `reqAddr` is the low 16 bits of ADDRLO with zero extension. When it is 1, `reqAddr` is {ADDRHI[15:0], ADDRLO}.
- R10: `reqEhp` is 1 on every request and `reqSai` is `SAI_RESET`. `reqRootSpace` carries SAI register bits [19:16]. Writes to the SAI field and to bit 31 have no effect.
- R11: A completion accepted while a non-posted request waits is stored as follows: data at offset 7, SAI at offset 8, and at offset 9 the status in [2:0] (000 success, 001 unsupported) and the header flag in bit 8. It also sets offset 9 bit 31, which clears when 1 is written to it. `cplIrq` equals bit 31 AND NOT the mask in bit 30.
- R12: A completion arriving with no non-posted request outstanding changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| reqValid | output | 1 | Request offered |
| reqReady | input | 1 | Fabric accepts request |
| reqDest | output | 8 | Destination port |
| reqOpcode | output | 8 | Opcode |
| reqBe | output | 4 | Byte enables |
| reqMisc | output | 4 | {address-length, BAR[2:0]} |
| reqFid | output | 8 | Function ID |
| reqAddr | output | 48 | Request address |
| reqData | output | 32 | Request data |
| reqPosted | output | 1 | 1 = posted |
| reqRead | output | 1 | 1 = read |
| reqEhp | output | 1 | Extended header present |
| reqSai | output | SAI_W | Requester SAI |
| reqRootSpace | output | 4 | Root space |
| cplValid | input | 1 | Completion strobe |
| cplData | input | 32 | Completion data |
| cplSai | input | SAI_W | Completion SAI |
| cplStatus | input | 3 | Completion status |
| cplEhp | input | 1 | Completion header flag |
| sentIrq | output | 1 | Request-sent interrupt |
| cplIrq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit SAI that resets to 0x3C, and a reserved opcode window of 0x20 to 0x2F. With these values, the padded SAI readback and both edges of the reserved window can be checked against fixed numbers. Both address lengths are exercised, and so is a BAR with its top bit set. The completion path is driven while a request waits and again while nothing waits, so the capture gate is tested from both sides.

// File: rtl/sb_req_pkg.sv
package sb_req_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CMD     = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_ATTR    = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_ADDRLO  = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_ADDRHI  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_SAI     = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_CPLDATA = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_CPLSAI  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_CPLSTS  = 4'd9;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SEND, SEQ_WAIT} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launchPosted;
    logic launchNp;
    logic sent;
    logic cplCapture;
  } ctrlStrobes_t;
endpackage

// File: rtl/sb_req_seq.sv
module sb_req_seq #(
  parameter bit NEEDS_CPL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic launch,
  input  logic reqReady,
  input  logic cplValid,
  output logic sending,
  output logic busy,
  output logic sentPulse,
  output logic cplPulse
);
  import sb_req_pkg::*;

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (launch) stateNext = SEQ_SEND;
      SEQ_SEND: if (reqReady) stateNext = NEEDS_CPL ? SEQ_WAIT : SEQ_IDLE;
      SEQ_WAIT: if (cplValid) stateNext = SEQ_IDLE;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign sending   = (state == SEQ_SEND);
  assign busy      = (state != SEQ_IDLE);
  assign sentPulse = sending && reqReady;
  assign cplPulse  = NEEDS_CPL && (state == SEQ_WAIT) && cplValid;

  // R7: a waiting non-posted sequencer stays busy without a completion
  p_wait_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_WAIT) && !cplValid |=> busy);
endmodule

// File: rtl/sb_req_ctrl.sv
module sb_req_ctrl #(
  parameter logic [7:0] RSV_LO = 8'h20,
  parameter logic [7:0] RSV_HI = 8'h2F
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdGo,
  input  logic                     cmdPosted,
  input  logic [7:0]               opcode,
  input  logic                     reqReady,
  input  logic                     cplValid,
  output logic                     reqValid,
  output logic                     busy,
  output sb_req_pkg::ctrlStrobes_t strobes
);
  import sb_req_pkg::*;

  localparam int NUM_SEQ = 2;

  logic                isReserved;
  logic                launch;
  logic [NUM_SEQ-1:0]  launchVec, sendingVec, busyVec, sentVec, cplVec;

  assign isReserved = (opcode >= RSV_LO) && (opcode <= RSV_HI);
  assign launch     = cmdGo && !isReserved && !busy;
  assign launchVec  = {launch && !cmdPosted, launch && cmdPosted};

  // index 0: posted sequencer, index 1: non-posted sequencer
  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    sb_req_seq #(.NEEDS_CPL(g == 1)) u_seq (
      .clk      (clk),
      .rstN     (rstN),
      .launch   (launchVec[g]),
      .reqReady (reqReady),
      .cplValid (cplValid),
      .sending  (sendingVec[g]),
      .busy     (busyVec[g]),
      .sentPulse(sentVec[g]),
      .cplPulse (cplVec[g])
    );
  end

  assign busy     = |busyVec;
  assign reqValid = |sendingVec;

  always_comb begin
    strobes.launchPosted = launchVec[0];
    strobes.launchNp     = launchVec[1];
    strobes.sent         = |sentVec;
    strobes.cplCapture   = |cplVec;
  end

  // R2: an offered request is held until accepted
  p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid);
  // R4: a reserved opcode never starts a sequencer
  p_reserved_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdGo && isReserved && !busy |=> !busy);
  // R7: at most one sequencer offers a request
  p_single_send_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sendingVec));
endmodule

// File: rtl/sb_req_datapath.sv
module sb_req_datapath #(
  parameter int              SAI_W     = 8,
  parameter logic [SAI_W-1:0] SAI_RESET = 8'h3C
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [sb_req_pkg::ADDR_W-1:0] regAddr,
  input  logic [sb_req_pkg::REG_W-1:0]  regWrData,
  output logic [sb_req_pkg::REG_W-1:0]  regRdData,
  input  sb_req_pkg::ctrlStrobes_t      strobes,
  input  logic                          busy,
  output logic                          cmdGo,
  output logic                          cmdPosted,
  output logic [7:0]                    opcode,
  output logic [7:0]                    reqDest,
  output logic [7:0]                    reqOpcode,
  output logic [3:0]                    reqBe,
  output logic [3:0]                    reqMisc,
  output logic [7:0]                    reqFid,
  output logic [47:0]                   reqAddr,
  output logic [31:0]                   reqData,
  output logic                          reqPosted,
  output logic                          reqRead,
  output logic [3:0]                    reqRootSpace,
  input  logic [31:0]                   cplData,
  input  logic [SAI_W-1:0]              cplSai,
  input  logic [2:0]                    cplStatus,
  input  logic                          cplEhp,
  output logic                          sentIrq,
  output logic                          cplIrq
);
  import sb_req_pkg::*;

  localparam int SAI_PAD = 16 - SAI_W;

  logic        wrCmd, wrStat, wrAttr, wrAddrLo, wrAddrHi, wrData, wrSai, wrCplSts;
  logic        dirReg, postedReg, sentIe, sentSts;
  logic [7:0]  destReg, opcReg, fidReg;
  logic [3:0]  beReg, barReg, rsReg;
  logic [31:0] addrLoReg, dataReg, cplDataReg;
  logic [15:0] addrUpReg;
  logic        addrLong;
  logic [SAI_W-1:0] cplSaiReg;
  logic [2:0]  cplStsReg;
  logic        cplEhpReg, cplMask, cplRcv;
  logic        launchAny;
  logic [47:0] addrOut;

  assign wrCmd    = regWrEn && (regAddr == OFS_CMD);
  assign wrStat   = regWrEn && (regAddr == OFS_STAT);
  assign wrAttr   = regWrEn && (regAddr == OFS_ATTR);
  assign wrAddrLo = regWrEn && (regAddr == OFS_ADDRLO);
  assign wrAddrHi = regWrEn && (regAddr == OFS_ADDRHI);
  assign wrData   = regWrEn && (regAddr == OFS_DATA);
  assign wrSai    = regWrEn && (regAddr == OFS_SAI);
  assign wrCplSts = regWrEn && (regAddr == OFS_CPLSTS);

  assign cmdGo     = wrCmd && regWrData[0];
  assign cmdPosted = regWrData[2];
  assign opcode    = opcReg;
  assign launchAny = strobes.launchPosted || strobes.launchNp;
  assign addrOut   = addrLong ? {addrUpReg, addrLoReg} : {32'd0, addrLoReg[15:0]};

  // programmable request fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= 1'b0; postedReg <= 1'b0; sentIe <= 1'b0;
      destReg <= '0; opcReg <= '0; beReg <= '0; barReg <= '0; fidReg <= '0;
      addrLoReg <= '0; addrUpReg <= '0; addrLong <= 1'b0;
      dataReg <= '0; rsReg <= '0;
    end else begin
      if (wrCmd) begin
        dirReg    <= regWrData[1];
        postedReg <= regWrData[2];
        sentIe    <= regWrData[3];
      end
      if (wrAttr) begin
        destReg <= regWrData[7:0];
        opcReg  <= regWrData[15:8];
        beReg   <= regWrData[19:16];
        barReg  <= regWrData[23:20];
        fidReg  <= regWrData[31:24];
      end
      if (wrAddrLo) addrLoReg <= regWrData;
      if (wrAddrHi) begin
        addrUpReg <= regWrData[15:0];
        addrLong  <= regWrData[31];
      end
      if (wrData) dataReg <= regWrData;
      if (wrSai)  rsReg   <= regWrData[19:16];
    end
  end

  // snapshot taken at launch, held for the life of the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqDest <= '0; reqOpcode <= '0; reqBe <= '0; reqMisc <= '0; reqFid <= '0;
      reqAddr <= '0; reqData <= '0; reqPosted <= 1'b0; reqRead <= 1'b0;
      reqRootSpace <= '0;
    end else if (launchAny) begin
      reqDest      <= destReg;
      reqOpcode    <= opcReg;
      reqBe        <= beReg;
      reqMisc      <= {addrLong, barReg[2:0]};
      reqFid       <= fidReg;
      reqAddr      <= addrOut;
      reqData      <= dataReg;
      reqPosted    <= strobes.launchPosted;
      reqRead      <= strobes.launchNp && regWrData[1];
      reqRootSpace <= rsReg;
    end
  end

  // sticky status and completion capture; hardware set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sentSts <= 1'b0; cplRcv <= 1'b0; cplMask <= 1'b0;
      cplDataReg <= '0; cplSaiReg <= '0; cplStsReg <= '0; cplEhpReg <= 1'b0;
    end else begin
      if (strobes.sent)                  sentSts <= 1'b1;
      else if (wrStat && regWrData[1])   sentSts <= 1'b0;
      if (wrCplSts) cplMask <= regWrData[30];
      if (strobes.cplCapture) begin
        cplRcv     <= 1'b1;
        cplDataReg <= cplData;
        cplSaiReg  <= cplSai;
        cplStsReg  <= cplStatus;
        cplEhpReg  <= cplEhp;
      end else if (wrCplSts && regWrData[31]) begin
        cplRcv <= 1'b0;
      end
    end
  end

  assign sentIrq = sentSts && sentIe;
  assign cplIrq  = cplRcv && !cplMask;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      OFS_CMD:     regRdData = {28'd0, sentIe, postedReg, dirReg, 1'b0};
      OFS_STAT:    regRdData = {30'd0, sentSts, busy};
      OFS_ATTR:    regRdData = {fidReg, barReg, beReg, opcReg, destReg};
      OFS_ADDRLO:  regRdData = addrLoReg;
      OFS_ADDRHI:  regRdData = {addrLong, 15'd0, addrUpReg};
      OFS_DATA:    regRdData = dataReg;
      OFS_SAI:     regRdData = {1'b1, 11'd0, rsReg, {SAI_PAD{1'b0}}, SAI_RESET};
      OFS_CPLDATA: regRdData = cplDataReg;
      OFS_CPLSAI:  regRdData = {{(32-SAI_W){1'b0}}, cplSaiReg};
      OFS_CPLSTS:  regRdData = {cplRcv, cplMask, 21'd0, cplEhpReg, 5'd0, cplStsReg};
      default:     regRdData = '0;
    endcase
  end

  // R2: request fields change only at a launch
  p_snap_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !launchAny |=> $stable(reqAddr) && $stable(reqData) && $stable(reqMisc));
  // R8: an accepted request leaves the sent status set
  p_sent_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sent |=> sentSts);
  // R11: a captured completion is visible with its data
  p_cpl_capture_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cplCapture |=> cplRcv && (cplDataReg == $past(cplData)));
  // R12: without a capture the completion data register holds
  p_cpl_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cplCapture |=> $stable(cplDataReg));
endmodule

// File: rtl/sb_req_issuer.sv
module sb_req_issuer #(
  parameter int               SAI_W     = 8,
  parameter logic [SAI_W-1:0] SAI_RESET = 8'h3C,
  parameter logic [7:0]       RSV_LO    = 8'h20,
  parameter logic [7:0]       RSV_HI    = 8'h2F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [7:0]        reqDest,
  output logic [7:0]        reqOpcode,
  output logic [3:0]        reqBe,
  output logic [3:0]        reqMisc,
  output logic [7:0]        reqFid,
  output logic [47:0]       reqAddr,
  output logic [31:0]       reqData,
  output logic              reqPosted,
  output logic              reqRead,
  output logic              reqEhp,
  output logic [SAI_W-1:0]  reqSai,
  output logic [3:0]        reqRootSpace,
  input  logic              cplValid,
  input  logic [31:0]       cplData,
  input  logic [SAI_W-1:0]  cplSai,
  input  logic [2:0]        cplStatus,
  input  logic              cplEhp,
  output logic              sentIrq,
  output logic              cplIrq
);
  import sb_req_pkg::*;

  ctrlStrobes_t strobes;
  logic         busy, cmdGo, cmdPosted;
  logic [7:0]   opcode;

  assign reqEhp = 1'b1;
  assign reqSai = SAI_RESET;

  sb_req_ctrl #(.RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdGo    (cmdGo),
    .cmdPosted(cmdPosted),
    .opcode   (opcode),
    .reqReady (reqReady),
    .cplValid (cplValid),
    .reqValid (reqValid),
    .busy     (busy),
    .strobes  (strobes)
  );

  sb_req_datapath #(.SAI_W(SAI_W), .SAI_RESET(SAI_RESET)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .strobes     (strobes),
    .busy        (busy),
    .cmdGo       (cmdGo),
    .cmdPosted   (cmdPosted),
    .opcode      (opcode),
    .reqDest     (reqDest),
    .reqOpcode   (reqOpcode),
    .reqBe       (reqBe),
    .reqMisc     (reqMisc),
    .reqFid      (reqFid),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .reqPosted   (reqPosted),
    .reqRead     (reqRead),
    .reqRootSpace(reqRootSpace),
    .cplData     (cplData),
    .cplSai      (cplSai),
    .cplStatus   (cplStatus),
    .cplEhp      (cplEhp),
    .sentIrq     (sentIrq),
    .cplIrq      (cplIrq)
  );
endmodule

// File: tb/sb_req_issuer_tb.sv
module sb_req_issuer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid, reqReady = 1'b0;
  logic [7:0]  reqDest, reqOpcode, reqFid;
  logic [3:0]  reqBe, reqMisc, reqRootSpace;
  logic [47:0] reqAddr;
  logic [31:0] reqData;
  logic        reqPosted, reqRead, reqEhp;
  logic [7:0]  reqSai;
  logic        cplValid = 1'b0;
  logic [31:0] cplData = '0;
  logic [7:0]  cplSai = '0;
  logic [2:0]  cplStatus = '0;
  logic        cplEhp = 1'b0;
  logic        sentIrq, cplIrq;

  int vectors = 0;
  int fails = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  sb_req_issuer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqDest(reqDest), .reqOpcode(reqOpcode), .reqBe(reqBe),
    .reqMisc(reqMisc), .reqFid(reqFid), .reqAddr(reqAddr), .reqData(reqData),
    .reqPosted(reqPosted), .reqRead(reqRead), .reqEhp(reqEhp), .reqSai(reqSai),
    .reqRootSpace(reqRootSpace), .cplValid(cplValid), .cplData(cplData),
    .cplSai(cplSai), .cplStatus(cplStatus), .cplEhp(cplEhp),
    .sentIrq(sentIrq), .cplIrq(cplIrq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic testReset();
    check("R1 valid", {63'd0, reqValid}, 64'd0);
    regRead(4'd1, rd); check("R1 status", {32'd0, rd}, 64'd0);
    regRead(4'd2, rd); check("R1 attr", {32'd0, rd}, 64'd0);
    regRead(4'd6, rd); check("R1 sai", {32'd0, rd}, 64'h8000_003C);
    check("R1 irq", {62'd0, sentIrq, cplIrq}, 64'd0);
  endtask

  task automatic testPosted();
    regWrite(4'd2, 32'h33DF_405A);
    regWrite(4'd3, 32'h1234_5678);
    regWrite(4'd4, 32'h8000_ABCD);
    regWrite(4'd5, 32'hA5A5_0001);
    regWrite(4'd6, 32'h800F_00FF);
    regRead(4'd6, rd); check("R10 sai readback", {32'd0, rd}, 64'h800F_003C);
    regWrite(4'd0, 32'h7);
    check("R2 valid after launch", {63'd0, reqValid}, 64'd1);
    check("R6 posted read forced", {62'd0, reqPosted, reqRead}, 64'h2);
    check("R9 misc long", {60'd0, reqMisc}, 64'hD);
    check("R9 addr long", {16'd0, reqAddr}, 64'h0000_ABCD_1234_5678);
    check("R10 ehp sai rs", {51'd0, reqEhp, reqSai, reqRootSpace}, {51'd0, 1'b1, 8'h3C, 4'hF});
    check("R2 fields", {reqDest, reqOpcode, reqBe, reqFid, reqData}, {8'h5A, 8'h40, 4'hF, 8'h33, 32'hA5A5_0001});
    regRead(4'd0, rd); check("R3 go reads 0", {32'd0, rd}, 64'h6);
    regRead(4'd1, rd); check("R7 busy posted", {32'd0, rd}, 64'h1);
    regWrite(4'd3, 32'h0);
    check("R2 held while not ready", {15'd0, reqValid, reqAddr}, {16'd1, 48'hABCD_1234_5678});
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
    check("R2 valid drops", {63'd0, reqValid}, 64'd0);
    regRead(4'd1, rd); check("R8 sent set, idle", {32'd0, rd}, 64'h2);
    check("R8 irq disabled", {63'd0, sentIrq}, 64'd0);
    regWrite(4'd0, 32'h8);
    check("R8 irq enabled", {63'd0, sentIrq}, 64'd1);
    regRead(4'd1, rd); check("R8 enable keeps status", {32'd0, rd}, 64'h2);
    regWrite(4'd1, 32'h2);
    regRead(4'd1, rd); check("R8 w1c", {32'd0, rd}, 64'h0);
    check("R8 irq cleared", {63'd0, sentIrq}, 64'd0);
    regWrite(4'd0, 32'h0);
  endtask

  task automatic testReserved();
    regWrite(4'd2, 32'h0000_2000);
    regWrite(4'd0, 32'h5);
    check("R4 opcode 0x20 dropped", {63'd0, reqValid}, 64'd0);
    regRead(4'd1, rd); check("R4 no busy 0x20", {32'd0, rd}, 64'h0);
    regWrite(4'd2, 32'h0000_2F00);
    regWrite(4'd0, 32'h5);
    check("R4 opcode 0x2F dropped", {63'd0, reqValid}, 64'd0);
    regRead(4'd1, rd); check("R4 no sent 0x2F", {32'd0, rd}, 64'h0);
    regWrite(4'd2, 32'h0000_1F00);
    reqReady = 1'b1;
    regWrite(4'd0, 32'h5);
    check("R4 opcode 0x1F launches", {55'd0, reqValid, reqOpcode}, {55'd0, 1'b1, 8'h1F});
    @(negedge clk);
    regRead(4'd1, rd); check("R4 0x1F sent", {32'd0, rd}, 64'h2);
    regWrite(4'd1, 32'h2);
    regWrite(4'd2, 32'h0000_3000);
    regWrite(4'd0, 32'h5);
    check("R4 opcode 0x30 launches", {55'd0, reqValid, reqOpcode}, {55'd0, 1'b1, 8'h30});
    @(negedge clk);
    reqReady = 1'b0;
    regWrite(4'd1, 32'h2);
  endtask

  task automatic testNonPosted();
    regWrite(4'd2, 32'h00A3_1011);
    regWrite(4'd3, 32'hCAFE_BEEF);
    regWrite(4'd4, 32'h0000_7777);
    reqReady = 1'b1;
    regWrite(4'd0, 32'h3);
    check("R6 nonposted read", {61'd0, reqValid, reqPosted, reqRead}, 64'h5);
    check("R9 misc short bar top dropped", {60'd0, reqMisc}, 64'h2);
    check("R9 addr short", {16'd0, reqAddr}, 64'h0000_0000_0000_BEEF);
    @(negedge clk);
    check("R2 accepted", {63'd0, reqValid}, 64'd0);
    regRead(4'd1, rd); check("R7 busy waiting completion", {32'd0, rd}, 64'h3);
    regWrite(4'd0, 32'h3);
    check("R5 launch while busy dropped", {63'd0, reqValid}, 64'd0);
    reqReady = 1'b0;
    @(negedge clk);
    cplValid = 1'b1; cplData = 32'hDEAD_BEEF; cplSai = 8'hA5; cplStatus = 3'b001; cplEhp = 1'b1;
    @(negedge clk);
    cplValid = 1'b0; cplData = '0; cplSai = '0; cplStatus = '0; cplEhp = 1'b0;
    check("R11 irq", {63'd0, cplIrq}, 64'd1);
    regRead(4'd1, rd); check("R7 idle after completion", {32'd0, rd}, 64'h2);
    regRead(4'd7, rd); check("R11 data", {32'd0, rd}, 64'hDEAD_BEEF);
    regRead(4'd8, rd); check("R11 sai", {32'd0, rd}, 64'h0000_00A5);
    regRead(4'd9, rd); check("R11 status", {32'd0, rd}, 64'h8000_0101);
    regWrite(4'd9, 32'h4000_0000);
    check("R11 masked irq", {63'd0, cplIrq}, 64'd0);
    regRead(4'd9, rd); check("R11 mask keeps status", {32'd0, rd}, 64'hC000_0101);
    regWrite(4'd9, 32'hC000_0000);
    regRead(4'd9, rd); check("R11 w1c", {32'd0, rd}, 64'h4000_0101);
    regWrite(4'd9, 32'h0);
    regWrite(4'd1, 32'h2);
  endtask

  task automatic testStrayCompletion();
    @(negedge clk);
    cplValid = 1'b1; cplData = 32'h1111_2222; cplSai = 8'h77; cplStatus = 3'b000; cplEhp = 1'b0;
    @(negedge clk);
    cplValid = 1'b0;
    regRead(4'd7, rd); check("R12 data unchanged", {32'd0, rd}, 64'hDEAD_BEEF);
    regRead(4'd9, rd); check("R12 status unchanged", {32'd0, rd}, 64'h0000_0101);
    check("R12 no irq", {63'd0, cplIrq}, 64'd0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPosted();
    testReserved();
    testNonPosted();
    testStrayCompletion();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule